// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache with Range Maintenance

This block sits between a processor load/store port and a plain word-wide memory port. It keeps a direct-mapped store of 32-byte lines. Each line is eight 32-bit words with a tag, a valid bit and a dirty bit. Loads and stores that hit are served from the line store. A miss streams the missing line in from memory at one word per clock. If the line being replaced holds modified data, that old line is first streamed out in the same way.

Software can also name an inclusive span of byte addresses and apply one of three maintenance actions to the cached lines inside it:
- **Discard:** drop the lines without saving them.
- **Clean:** save dirty lines to memory and keep them cached.
- **Evict:** save dirty lines to memory and then drop them.

A walker visits the span one line address at a time. It reports completion with a one-cycle pulse. While any multi-cycle activity is under way, the core port holds off new requests.

Top module: `wb_range_cache`

## Requirements
- R1: After reset every line is invalid, `core_req_ready` is high, and `mem_req`, `core_rsp_valid` and `maint_done` are low.
- R2: A read that hits returns the stored word with `core_rsp_valid` high in the cycle right after the accepting edge, and causes no memory traffic.
- R3: A write that hits updates only the cached word and marks the line dirty, with no memory write. A later read returns the new value.
- R4: A miss to a clean or invalid line reads the eight words of the line from memory at word offsets 0 to 7 in ascending order, one read per consecutive clock. Memory returns each word in the cycle after its request. The response follows the fill.
- R5: A miss that replaces a dirty line first writes the eight old words to memory, at the old line's address, in ascending order on consecutive clocks. Only then does the first fill read go out.
- R6: `core_req_ready` is low whenever a fill, a victim write-back or a maintenance command is in progress.
- R7: Maintenance code 1 (discard) invalidates every matching line in range and writes nothing to memory, even for dirty lines.
- R8: Maintenance code 2 (clean) writes each dirty matching line to memory and leaves it valid and clean. A repeat of the command then writes nothing.
- R9: Maintenance code 3 (evict) writes each dirty matching line to memory and then invalidates it.
- R10: The span covers every line from the one holding `maint_lo` to the one holding `maint_hi`, both included, visited in ascending order. Lines outside the span are left alone. So is any entry whose tag differs from the visited line address.
- R11: `maint_done` is high for exactly one cycle when a command ends. If the start line lies above the end line, the command ends with no action.
- R12: Maintenance code 0 is ignored: no done pulse, no memory traffic, and no change to cached lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_req_valid | input | 1 | Core request present |
| core_req_write | input | 1 | 1 = store, 0 = load |
| core_req_addr | input | 32 | Byte address (word aligned) |
| core_req_wdata | input | 32 | Store data |
| core_req_ready | output | 1 | Request accepted on this edge when valid |
| core_rsp_valid | output | 1 | Response strobe, one cycle |
| core_rsp_rdata | output | 32 | Load data (undefined for stores) |
| maint_valid | input | 1 | Maintenance command present |
| maint_op | input | 2 | 0 none, 1 discard, 2 clean, 3 evict |
| maint_lo | input | 32 | First byte address of span |
| maint_hi | input | 32 | Last byte address of span |
| maint_done | output | 1 | Command finished, one-cycle pulse |
| mem_req | output | 1 | Memory access this cycle |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word address in bytes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |

## Verification
A stuck or wrong dirty bit shows at the memory port when the next conflicting miss or clean command runs. An extra or missing eight-word write burst appears there within a few cycles. A wrong valid or tag entry shows as memory reads on an access expected to hit, or as a stale load value in the very next response. A wrong walker bound appears as write bursts at addresses outside the span, or as a missing done pulse. The bench therefore logs every memory access with its cycle number and checks order, addresses and spacing, as well as load data.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  typedef enum logic [1:0] {
    MOP_NONE    = 2'd0,
    MOP_DISCARD = 2'd1,
    MOP_CLEAN   = 2'd2,
    MOP_EVICT   = 2'd3
  } mop_e;

  typedef enum logic [2:0] {
    S_IDLE, S_VICTIM, S_FILL, S_REPLAY, S_SCAN, S_MWB, S_MDONE
  } st_e;

  localparam int LINE_WORDS = 8;
  localparam int WSEL_W     = $clog2(LINE_WORDS);
  localparam int LINE_OFS_W = WSEL_W + 2;
endpackage

// File: rtl/wbc_tag_store.sv
module wbc_tag_store #(
  parameter int IDXW = 5,
  parameter int TAGW = 22
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IDXW-1:0] idx,
  output logic            valid_o,
  output logic            dirty_o,
  output logic [TAGW-1:0] tag_o,
  input  logic            install,
  input  logic [TAGW-1:0] install_tag,
  input  logic            set_dirty,
  input  logic            clr_dirty,
  input  logic            clr_valid
);
  localparam int LINES = 1 << IDXW;

  logic [LINES-1:0] v_q, v_d, dt_q, dt_d;
  logic [TAGW-1:0]  tag_q [LINES];

  always_comb begin
    v_d  = v_q;
    dt_d = dt_q;
    if (install)   begin v_d[idx] = 1'b1; dt_d[idx] = 1'b0; end
    if (set_dirty) dt_d[idx] = 1'b1;
    if (clr_dirty) dt_d[idx] = 1'b0;
    if (clr_valid) begin v_d[idx] = 1'b0; dt_d[idx] = 1'b0; end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q  <= '0;
      dt_q <= '0;
    end else begin
      v_q  <= v_d;
      dt_q <= dt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (install) tag_q[idx] <= install_tag;
  end

  assign valid_o = v_q[idx];
  assign dirty_o = dt_q[idx];
  assign tag_o   = tag_q[idx];

  // R3: a store marks only a line that is already resident
  p_dirty_on_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set_dirty |-> v_q[idx]);
  // R3: marking dirty never collides with a clear or a refill
  p_dirty_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set_dirty |-> !(clr_dirty || clr_valid || install));
  // R4: a freshly filled line is valid and clean
  p_install_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
    install |=> (v_q[$past(idx)] && !dt_q[$past(idx)]));
endmodule

// File: rtl/wbc_data_store.sv
module wbc_data_store #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);
  localparam int DEPTH = 1 << AW;

  logic [31:0] word_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) word_q[waddr] <= wdata;
  end

  assign rdata = word_q[raddr];
endmodule

// File: rtl/wb_range_cache.sv
module wb_range_cache
  import wbc_pkg::*;
#(
  parameter int CACHE_KB = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        core_req_valid,
  input  logic        core_req_write,
  input  logic [31:0] core_req_addr,
  input  logic [31:0] core_req_wdata,
  output logic        core_req_ready,
  output logic        core_rsp_valid,
  output logic [31:0] core_rsp_rdata,
  input  logic        maint_valid,
  input  logic [1:0]  maint_op,
  input  logic [31:0] maint_lo,
  input  logic [31:0] maint_hi,
  output logic        maint_done,
  output logic        mem_req,
  output logic        mem_write,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata
);
  localparam int LINES = CACHE_KB * 1024 / (LINE_WORDS * 4);
  localparam int IDXW  = $clog2(LINES);
  localparam int TAGW  = 32 - LINE_OFS_W - IDXW;
  localparam int LAW   = 32 - LINE_OFS_W;

  st_e                st_q, st_d;
  mop_e               mop_q, mop_d;
  logic [WSEL_W:0]    cnt_q, cnt_d;
  logic               rdv_q, rdv_d;
  logic [WSEL_W-1:0]  rdw_q, rdw_d;
  logic               pw_q, pw_d;
  logic [31:0]        pa_q, pa_d, pd_q, pd_d;
  logic [LAW-1:0]     cur_q, cur_d, hi_q, hi_d;
  logic [TAGW-1:0]    vt_q, vt_d;
  logic               rv_q, rv_d;
  logic [31:0]        rdat_q, rdat_d;

  logic               t_valid, t_dirty, install, set_dirty, clr_dirty, clr_valid;
  logic [TAGW-1:0]    t_tag;
  logic [IDXW-1:0]    t_idx;
  logic [31:0]        a_addr, a_wdata, d_rdata, d_wdata;
  logic               a_write, hit, s_hit, maint_go, d_we;
  logic [IDXW+WSEL_W-1:0] d_raddr, d_waddr;

  assign maint_go = maint_valid && (maint_op != 2'b00);
  assign a_addr   = (st_q == S_IDLE) ? core_req_addr  : pa_q;
  assign a_write  = (st_q == S_IDLE) ? core_req_write : pw_q;
  assign a_wdata  = (st_q == S_IDLE) ? core_req_wdata : pd_q;
  assign t_idx    = (st_q == S_SCAN || st_q == S_MWB) ? cur_q[IDXW-1:0]
                                                       : a_addr[LINE_OFS_W +: IDXW];
  assign hit      = t_valid && (t_tag == a_addr[31 -: TAGW]);
  assign s_hit    = t_valid && (t_tag == cur_q[LAW-1 -: TAGW]);
  assign d_raddr  = (st_q == S_VICTIM || st_q == S_MWB) ? {t_idx, cnt_q[WSEL_W-1:0]}
                                                         : {t_idx, a_addr[LINE_OFS_W-1:2]};

  wbc_tag_store #(.IDXW(IDXW), .TAGW(TAGW)) i_tags (
    .clk(clk), .rst_n(rst_n), .idx(t_idx),
    .valid_o(t_valid), .dirty_o(t_dirty), .tag_o(t_tag),
    .install(install), .install_tag(pa_q[31 -: TAGW]),
    .set_dirty(set_dirty), .clr_dirty(clr_dirty), .clr_valid(clr_valid)
  );

  wbc_data_store #(.AW(IDXW + WSEL_W)) i_data (
    .clk(clk), .we(d_we), .waddr(d_waddr), .wdata(d_wdata),
    .raddr(d_raddr), .rdata(d_rdata)
  );

  always_comb begin
    st_d = st_q;  mop_d = mop_q;  cnt_d = cnt_q;
    rdv_d = 1'b0; rdw_d = rdw_q;
    pw_d = pw_q;  pa_d = pa_q;  pd_d = pd_q;
    cur_d = cur_q; hi_d = hi_q; vt_d = vt_q;
    rv_d = 1'b0;  rdat_d = rdat_q;
    install = 1'b0; set_dirty = 1'b0; clr_dirty = 1'b0; clr_valid = 1'b0;
    d_we    = rdv_q;
    d_waddr = {pa_q[LINE_OFS_W +: IDXW], rdw_q};
    d_wdata = mem_rdata;
    mem_req = 1'b0; mem_write = 1'b0; mem_addr = '0; mem_wdata = d_rdata;
    maint_done = 1'b0;
    core_req_ready = (st_q == S_IDLE) && !maint_go;

    unique case (st_q)
      S_IDLE: begin
        if (maint_go) begin
          mop_d = mop_e'(maint_op);
          cur_d = maint_lo[31:LINE_OFS_W];
          hi_d  = maint_hi[31:LINE_OFS_W];
          st_d  = S_SCAN;
        end else if (core_req_valid) begin
          pw_d = core_req_write; pa_d = core_req_addr; pd_d = core_req_wdata;
          if (!hit) begin
            vt_d  = t_tag;
            cnt_d = '0;
            st_d  = (t_valid && t_dirty) ? S_VICTIM : S_FILL;
          end
        end
      end
      S_VICTIM: begin
        mem_req = 1'b1; mem_write = 1'b1;
        mem_addr = {vt_q, t_idx, cnt_q[WSEL_W-1:0], 2'b00};
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == (WSEL_W+1)'(LINE_WORDS-1)) begin cnt_d = '0; st_d = S_FILL; end
      end
      S_FILL: begin
        if (cnt_q != (WSEL_W+1)'(LINE_WORDS)) begin
          mem_req  = 1'b1;
          mem_addr = {pa_q[31:LINE_OFS_W], cnt_q[WSEL_W-1:0], 2'b00};
          rdv_d = 1'b1; rdw_d = cnt_q[WSEL_W-1:0];
          cnt_d = cnt_q + 1'b1;
        end else begin
          install = 1'b1;
          st_d    = S_REPLAY;
        end
      end
      S_REPLAY: st_d = S_IDLE;
      S_SCAN: begin
        if (cur_q > hi_q) st_d = S_MDONE;
        else if (s_hit && t_dirty && mop_q != MOP_DISCARD) begin
          cnt_d = '0; st_d = S_MWB;
        end else begin
          clr_valid = s_hit && (mop_q != MOP_CLEAN);
          if (cur_q == hi_q) st_d = S_MDONE; else cur_d = cur_q + 1'b1;
        end
      end
      S_MWB: begin
        mem_req = 1'b1; mem_write = 1'b1;
        mem_addr = {cur_q, cnt_q[WSEL_W-1:0], 2'b00};
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == (WSEL_W+1)'(LINE_WORDS-1)) begin
          clr_dirty = 1'b1;
          clr_valid = (mop_q == MOP_EVICT);
          st_d = S_SCAN;
          if (cur_q == hi_q) st_d = S_MDONE; else cur_d = cur_q + 1'b1;
        end
      end
      S_MDONE: begin maint_done = 1'b1; st_d = S_IDLE; end
      default: st_d = S_IDLE;
    endcase

    if ((st_q == S_REPLAY) || (st_q == S_IDLE && !maint_go && core_req_valid && hit)) begin
      rv_d   = 1'b1;
      rdat_d = d_rdata;
      if (a_write) begin
        d_we = 1'b1; d_waddr = {t_idx, a_addr[LINE_OFS_W-1:2]}; d_wdata = a_wdata;
        set_dirty = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; mop_q <= MOP_NONE; cnt_q <= '0; rdv_q <= 1'b0; rdw_q <= '0;
      pw_q <= 1'b0; pa_q <= '0; pd_q <= '0; cur_q <= '0; hi_q <= '0; vt_q <= '0;
      rv_q <= 1'b0; rdat_q <= '0;
    end else begin
      st_q <= st_d; mop_q <= mop_d; cnt_q <= cnt_d; rdv_q <= rdv_d; rdw_q <= rdw_d;
      pw_q <= pw_d; pa_q <= pa_d; pd_q <= pd_d; cur_q <= cur_d; hi_q <= hi_d; vt_q <= vt_d;
      rv_q <= rv_d; rdat_q <= rdat_d;
    end
  end

  assign core_rsp_valid = rv_q;
  assign core_rsp_rdata = rdat_q;

  // R6: no new request is taken while memory is being driven
  p_busy_no_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !core_req_ready);
  // R11: completion strobe lasts one cycle
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    maint_done |=> !maint_done);
  // R5: every burst starts at word 0 of a line
  p_burst_base_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> (mem_addr[LINE_OFS_W-1:2] == '0));
  // R2: a response never overlaps memory traffic
  p_rsp_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    core_rsp_valid |-> !mem_req);
  // R10: maintenance writes stay inside the span
  p_walk_inside_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_write && maint_done == 1'b0 && !core_req_ready && st_q == S_MWB)
      |-> (mem_addr[31:LINE_OFS_W] <= hi_q));
endmodule

// File: tb/test_wb_range_cache.sv
`timescale 1ns/1ps
module test_wb_range_cache;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        core_req_valid, core_req_write;
  logic [31:0] core_req_addr, core_req_wdata;
  logic        core_req_ready, core_rsp_valid;
  logic [31:0] core_rsp_rdata;
  logic        maint_valid;
  logic [1:0]  maint_op;
  logic [31:0] maint_lo, maint_hi;
  logic        maint_done;
  logic        mem_req, mem_write;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int n_chk = 0, n_fail = 0, rdy_bad = 0, cyc = 0;
  logic [31:0] mem_img [0:4095];
  logic [31:0] ref_img [0:4095];
  logic [32:0] exp_q [$];
  int          log_n = 0;
  logic        log_we   [0:63];
  logic [31:0] log_addr [0:63];
  int          log_t    [0:63];

  always #2.5 clk = ~clk;

  wb_range_cache #(.CACHE_KB(1)) i_wb_range_cache (
    .clk(clk), .rst_n(rst_n),
    .core_req_valid(core_req_valid), .core_req_write(core_req_write),
    .core_req_addr(core_req_addr), .core_req_wdata(core_req_wdata),
    .core_req_ready(core_req_ready), .core_rsp_valid(core_rsp_valid),
    .core_rsp_rdata(core_rsp_rdata),
    .maint_valid(maint_valid), .maint_op(maint_op), .maint_lo(maint_lo),
    .maint_hi(maint_hi), .maint_done(maint_done),
    .mem_req(mem_req), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] ival(input logic [31:0] a);
    return 32'hC0DE0000 ^ {a[31:2], 2'b00};
  endfunction

  // memory model: write in place, read data one cycle later
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (mem_req) begin
      if (mem_write) mem_img[mem_addr[13:2]] <= mem_wdata;
      else           mem_rdata <= mem_img[mem_addr[13:2]];
      if (log_n < 64) begin
        log_we[log_n] = mem_write; log_addr[log_n] = mem_addr; log_t[log_n] = cyc;
      end
      log_n = log_n + 1;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // monitor: scoreboard pops and compares responses
  always @(negedge clk) begin
    if (rst_n && mem_req && core_req_ready) rdy_bad++;
    if (rst_n && core_rsp_valid) begin
      if (exp_q.size() == 0) chk(0, "R2", "unexpected response", core_rsp_rdata, 0);
      else begin
        logic [32:0] e;
        e = exp_q.pop_front();
        if (e[32]) chk(core_rsp_rdata == e[31:0], "R3", "load data", core_rsp_rdata, e[31:0]);
      end
    end
  end

  task automatic clear_log();
    @(negedge clk); log_n = 0;
  endtask

  task automatic do_req(input bit we, input logic [31:0] a, input logic [31:0] wd,
                        input bit hit_exp);
    @(negedge clk);
    while (!core_req_ready) @(negedge clk);
    core_req_valid = 1'b1; core_req_write = we; core_req_addr = a; core_req_wdata = wd;
    if (we) begin exp_q.push_back({1'b0, 32'h0}); ref_img[a[13:2]] = wd; end
    else exp_q.push_back({1'b1, ref_img[a[13:2]]});
    @(posedge clk); #1;
    core_req_valid = 1'b0;
    if (hit_exp) begin
      @(negedge clk);
      chk(core_rsp_valid == 1'b1, "R2", "hit latency", {31'b0, core_rsp_valid}, 1);
    end
    for (int k = 0; k < 400 && exp_q.size() != 0; k++) @(negedge clk);
    chk(exp_q.size() == 0, "R4", "response arrived", exp_q.size(), 0);
  endtask

  task automatic do_mnt(input logic [1:0] op, input logic [31:0] lo, input logic [31:0] hi);
    bit seen = 0;
    @(negedge clk);
    while (!core_req_ready) @(negedge clk);
    maint_valid = 1'b1; maint_op = op; maint_lo = lo; maint_hi = hi;
    @(posedge clk); #1;
    maint_valid = 1'b0;
    @(negedge clk);
    chk(core_req_ready == 1'b0 || maint_done, "R6", "busy during walk", {31'b0, core_req_ready}, 0);
    for (int k = 0; k < 2000 && !seen; k++) begin
      if (maint_done) seen = 1; else @(negedge clk);
    end
    chk(seen, "R11", "done seen", {31'b0, seen}, 1);
    @(negedge clk);
    chk(maint_done == 1'b0, "R11", "done one cycle", {31'b0, maint_done}, 0);
  endtask

  task automatic chk_burst(input int s, input bit we, input logic [31:0] base, input string rq);
    for (int k = 0; k < 8; k++) begin
      chk(log_we[s+k] == we && log_addr[s+k] == base + 32'(4*k), rq, "burst addr",
          log_addr[s+k], base + 32'(4*k));
      chk(log_t[s+k] == log_t[s] + k, rq, "burst spacing", log_t[s+k], log_t[s] + k);
    end
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) begin
      mem_img[i] = ival(32'(i * 4)); ref_img[i] = ival(32'(i * 4));
    end
    rst_n = 1'b0; core_req_valid = 1'b0; core_req_write = 1'b0;
    core_req_addr = '0; core_req_wdata = '0; maint_valid = 1'b0; maint_op = '0;
    maint_lo = '0; maint_hi = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(core_req_ready && !mem_req && !core_rsp_valid && !maint_done, "R1", "reset outputs",
        {core_req_ready, mem_req, core_rsp_valid, maint_done}, 4'b1000);

    // R1/R4 first access misses and fills
    clear_log(); do_req(0, 32'h100, 0, 0);
    chk(log_n == 8, "R4", "fill read count", log_n, 8);
    chk_burst(0, 0, 32'h100, "R4");

    // R2 read hit
    clear_log(); do_req(0, 32'h104, 0, 1);
    chk(log_n == 0, "R2", "hit traffic", log_n, 0);

    // R3 write hit stays in cache
    clear_log(); do_req(1, 32'h108, 32'hDEAD0001, 1);
    chk(log_n == 0, "R3", "store traffic", log_n, 0);
    chk(mem_img[32'h108 >> 2] == ival(32'h108), "R3", "memory untouched",
        mem_img[32'h108 >> 2], ival(32'h108));
    do_req(0, 32'h108, 0, 1);

    // R5 dirty victim
    clear_log(); do_req(0, 32'h500, 0, 0);
    chk(log_n == 16, "R5", "victim+fill count", log_n, 16);
    chk_burst(0, 1, 32'h100, "R5");
    chk_burst(8, 0, 32'h500, "R5");
    chk(mem_img[32'h108 >> 2] == 32'hDEAD0001, "R5", "victim data", mem_img[32'h108 >> 2], 32'hDEAD0001);

    // R7 discard drops dirty data
    do_req(1, 32'h504, 32'h11112222, 1);
    clear_log(); do_mnt(2'd1, 32'h504, 32'h504);
    chk(log_n == 0, "R7", "discard writes", log_n, 0);
    ref_img[32'h504 >> 2] = ival(32'h504);
    clear_log(); do_req(0, 32'h504, 0, 0);
    chk(log_n == 8, "R7", "refetch after discard", log_n, 8);

    // R8 clean span of two lines, third line outside (R10)
    do_req(1, 32'h200, 32'hAAAA0200, 0);
    do_req(1, 32'h220, 32'hAAAA0220, 0);
    do_req(1, 32'h240, 32'hAAAA0240, 0);
    clear_log(); do_mnt(2'd2, 32'h204, 32'h23C);
    chk(log_n == 16, "R10", "span write count", log_n, 16);
    chk_burst(0, 1, 32'h200, "R10");
    chk_burst(8, 1, 32'h220, "R8");
    chk(mem_img[32'h220 >> 2] == 32'hAAAA0220, "R8", "clean data", mem_img[32'h220 >> 2], 32'hAAAA0220);
    clear_log(); do_req(0, 32'h220, 0, 1);
    chk(log_n == 0, "R8", "line stays valid", log_n, 0);
    clear_log(); do_mnt(2'd2, 32'h200, 32'h23F);
    chk(log_n == 0, "R8", "second clean idle", log_n, 0);

    // R9 evict
    clear_log(); do_mnt(2'd3, 32'h240, 32'h240);
    chk(log_n == 8, "R9", "evict writes", log_n, 8);
    chk_burst(0, 1, 32'h240, "R9");
    clear_log(); do_req(0, 32'h244, 0, 0);
    chk(log_n == 8, "R9", "refetch after evict", log_n, 8);

    // R10 tag mismatch at same index
    do_req(1, 32'h300, 32'h33334444, 0);
    clear_log(); do_mnt(2'd3, 32'h700, 32'h71F);
    chk(log_n == 0, "R10", "other tag untouched", log_n, 0);
    clear_log(); do_req(0, 32'h300, 0, 1);
    chk(log_n == 0, "R10", "line still resident", log_n, 0);

    // R11 reversed span
    clear_log(); do_mnt(2'd3, 32'h400, 32'h2E0);
    chk(log_n == 0, "R11", "reversed span idle", log_n, 0);
    clear_log(); do_req(0, 32'h300, 0, 1);
    chk(log_n == 0, "R11", "reversed span no evict", log_n, 0);

    // R12 code 0 ignored
    begin
      bit dn = 0;
      clear_log();
      maint_valid = 1'b1; maint_op = 2'd0; maint_lo = 32'h300; maint_hi = 32'h31F;
      @(posedge clk); #1; maint_valid = 1'b0;
      for (int k = 0; k < 20; k++) begin @(negedge clk); if (maint_done) dn = 1; end
      chk(!dn, "R12", "no done", {31'b0, dn}, 0);
      chk(log_n == 0, "R12", "no traffic", log_n, 0);
      do_req(0, 32'h300, 0, 1);
      chk(log_n == 0, "R12", "line unchanged", log_n, 0);
    end

    chk(rdy_bad == 0, "R6", "ready while busy", rdy_bad, 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule